// File: doc/BRIEF.md
# Instruction Repeat Controller

This sequencer runs the instruction that follows a repeat command several times over. A repeat strobe loads a 12-bit iteration count and a 3-bit stepping mode into an index-file slot that acts as a down-counter: the mode sits in bits 14:12 and the count in bits 11:0. The controller then takes the fetched instruction and applies the instruction's own index offset once, on the first pass only. It then issues the instruction, one strobe per pass. After each pass it may raise or lower the 15-bit address field by one, depending on the mode.

Each issue waits for an execute-complete handshake from the execution side. Every completed pass takes one from the count. The loop stops in any of these cases:

- the count reaches zero;
- the pass reports a taken jump or skip;
- an external disconnect was seen;
- the repeated opcode is one that may run only once.

When the loop stops, the count of passes not run stays in the counter and the mode bits are cleared. A count of zero skips the instruction with no issue at all.

Top module: `rpt_ctrl`

## Requirements
- R1: After reset, `issue` and `done` are low and `reg7` is zero.
- R2: One cycle after `rpt_start` is taken while idle, `reg7` holds {mode, count}: mode in bits 14:12 and count in bits 11:0.
- R3: The first issued word keeps bits 23:15 of the fetched instruction. Its bits 14:0 are the fetched bits 14:0 plus `idx_val`, modulo 2^15, when the index select (bits 17:15) is nonzero, and the fetched bits unchanged when it is zero.
- R4: Each later issue takes the previous issued field plus one for modes 1 and 3, or minus one for modes 5 and 7, modulo 2^15. For modes 0, 2, 4 and 6 the field is unchanged. The index offset is never applied again.
- R5: `issue` is high for exactly one cycle per pass. No further issue occurs until `exec_done` is seen.
- R6: Each `exec_done` lowers the count in `reg7[11:0]` by one. When it reaches zero, `done` pulses in the cycle after that `exec_done`, so a count of N yields exactly N issues.
- R7: A `jump_taken` given with `exec_done` ends the loop after that pass and leaves the remaining count in `reg7`.
- R8: A `disconnect` pulse during a pass ends the loop when that pass's `exec_done` arrives, and leaves the remaining count.
- R9: An instruction whose opcode (bits 23:18) is 1 through 7 is issued once. The loop then ends with the count lowered by one.
- R10: A count of zero produces no issue, and `done` pulses in the cycle after the instruction is presented.
- R11: Whenever `done` is high, `reg7[14:12]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_start | input | 1 | Repeat command strobe |
| rpt_count | input | 12 | Iteration count |
| rpt_mode | input | 3 | Address stepping mode |
| instr_valid | input | 1 | Fetched instruction present |
| instr | input | 24 | Instruction to repeat |
| idx_val | input | 15 | Contents of the index register the instruction selects |
| exec_done | input | 1 | Execute-complete handshake |
| jump_taken | input | 1 | The pass jumped or skipped (valid with exec_done) |
| disconnect | input | 1 | External request to stop |
| issue | output | 1 | One-cycle issue strobe |
| issue_instr | output | 24 | Instruction as modified for this pass |
| reg7 | output | 15 | Counter register: mode and remaining count |
| done | output | 1 | One-cycle end-of-repeat pulse |

## Verification
A wrong address step shows on `issue_instr` at the very next issue after the faulty pass, so the bench compares every issued word. A count off by one appears in `reg7` one cycle after the affected handshake. It also appears as an extra or missing issue before `done`. A lost stop cause (jump, disconnect or once-only opcode) shows as a further issue strobe where `done` was due, in the cycle right after the ending handshake.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  parameter int WORD_W  = 24;
  parameter int OP_W    = 6;
  parameter int SEL_W   = 3;
  parameter int FIELD_W = 15;
  parameter int MODE_W  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ISSUE, ST_EXEC} rpt_state_e;

  // address field after one pass: odd modes step, bit 2 picks the direction
  function automatic logic [FIELD_W-1:0] field_step(input logic [FIELD_W-1:0] f,
                                                    input logic [MODE_W-1:0] m);
    if (!m[0])      return f;
    else if (m[2])  return f - FIELD_W'(1);
    else            return f + FIELD_W'(1);
  endfunction

  // opcodes that may run only once under repeat
  function automatic logic once_only(input logic [OP_W-1:0] op);
    return (op != '0) && (op < OP_W'(8));
  endfunction

  // first pass: the instruction's own index offset
  function automatic logic [FIELD_W-1:0] first_field(input logic [WORD_W-1:0] w,
                                                     input logic [FIELD_W-1:0] idx);
    logic [SEL_W-1:0] sel;
    sel = w[FIELD_W +: SEL_W];
    return (sel != '0) ? (w[FIELD_W-1:0] + idx) : w[FIELD_W-1:0];
  endfunction
endpackage

// File: rtl/rpt_addr_unit.sv
module rpt_addr_unit
  import rpt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                advance,
  input  logic [WORD_W-1:0]   instr_in,
  input  logic [FIELD_W-1:0]  idx_in,
  input  logic [MODE_W-1:0]   mode,
  output logic [WORD_W-1:0]   work
);
  localparam int HI_W = WORD_W - FIELD_W;

  always_ff @(posedge clk) begin
    if (!rst_n)
      work <= '0;
    else if (load)
      work <= {instr_in[WORD_W-1 -: HI_W], first_field(instr_in, idx_in)};
    else if (advance)
      work <= {work[WORD_W-1 -: HI_W], field_step(work[FIELD_W-1:0], mode)};
  end
endmodule

// File: rtl/rpt_term_unit.sv
module rpt_term_unit #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             disconnect,
  input  logic [CNT_W-1:0] cnt,
  input  logic             jump_taken,
  input  logic             once_flag,
  output logic             stop
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);
  logic disc_pend;

  // a disconnect is held until the pass in flight completes
  always_ff @(posedge clk) begin
    if (!rst_n || !busy)
      disc_pend <= 1'b0;
    else if (disconnect)
      disc_pend <= 1'b1;
  end

  assign stop = (cnt == LAST) | jump_taken | disc_pend | disconnect | once_flag;
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
#(
  parameter int CNT_W = 12,
  localparam int REG_W = MODE_W + CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rpt_start,
  input  logic [CNT_W-1:0]    rpt_count,
  input  logic [MODE_W-1:0]   rpt_mode,
  input  logic                instr_valid,
  input  logic [WORD_W-1:0]   instr,
  input  logic [FIELD_W-1:0]  idx_val,
  input  logic                exec_done,
  input  logic                jump_taken,
  input  logic                disconnect,
  output logic                issue,
  output logic [WORD_W-1:0]   issue_instr,
  output logic [REG_W-1:0]    reg7,
  output logic                done
);
  rpt_state_e          st;
  logic [CNT_W-1:0]    cnt;
  logic [MODE_W-1:0]   mode;
  logic                once_q;
  logic                done_q;
  logic                stop;

  // named events for the checker
  logic busy, exec_ack, skip_evt, load, advance;
  assign busy     = (st != ST_IDLE);
  assign exec_ack = (st == ST_EXEC) && exec_done;
  assign skip_evt = (st == ST_FETCH) && instr_valid && (cnt == '0);
  assign load     = (st == ST_FETCH) && instr_valid && (cnt != '0);
  assign advance  = exec_ack && !stop;

  rpt_addr_unit u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .instr_in(instr), .idx_in(idx_val), .mode(mode), .work(issue_instr)
  );

  rpt_term_unit #(.CNT_W(CNT_W)) u_term (
    .clk(clk), .rst_n(rst_n), .busy(busy), .disconnect(disconnect),
    .cnt(cnt), .jump_taken(jump_taken), .once_flag(once_q), .stop(stop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mode   <= '0;
      once_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (rpt_start) begin
          cnt  <= rpt_count;
          mode <= rpt_mode;
          st   <= ST_FETCH;
        end
        ST_FETCH: if (instr_valid) begin
          if (cnt == '0) begin
            done_q <= 1'b1;
            mode   <= '0;
            st     <= ST_IDLE;
          end else begin
            once_q <= once_only(instr[WORD_W-1 -: OP_W]);
            st     <= ST_ISSUE;
          end
        end
        ST_ISSUE: st <= ST_EXEC;
        ST_EXEC: if (exec_done) begin
          cnt <= cnt - CNT_W'(1);
          if (stop) begin
            done_q <= 1'b1;
            mode   <= '0;
            st     <= ST_IDLE;
          end else begin
            st <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign issue = (st == ST_ISSUE);
  assign done  = done_q;
  assign reg7  = {mode, cnt};
endmodule

// File: rtl/rpt_ctrl_chk.sv
module rpt_ctrl_chk #(
  parameter int CNT_W = 12,
  parameter int REG_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic             done,
  input logic [REG_W-1:0] reg7,
  input logic             exec_ack,
  input logic             skip_evt,
  input logic             jump_taken,
  input logic             busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R5
  issue_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ack |=> reg7[CNT_W-1:0] == ($past(reg7[CNT_W-1:0]) - ONE));

  // R7
  jump_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ack && jump_taken) |=> (done && !issue));

  // R10
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> (done && !issue));

  // R11
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (reg7[REG_W-1:CNT_W] == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !issue);
endmodule

bind rpt_ctrl rpt_ctrl_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .done(done), .reg7(reg7),
  .exec_ack(exec_ack), .skip_evt(skip_evt), .jump_taken(jump_taken), .busy(busy)
);

// File: tb/sim_rpt_ctrl.sv
module sim_rpt_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rpt_start = 1'b0;
  logic [11:0] rpt_count = '0;
  logic [2:0]  rpt_mode = '0;
  logic        instr_valid = 1'b0;
  logic [23:0] instr = '0;
  logic [14:0] idx_val = '0;
  logic        exec_done = 1'b0;
  logic        jump_taken = 1'b0;
  logic        disconnect = 1'b0;
  logic        issue;
  logic [23:0] issue_instr;
  logic [14:0] reg7;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rpt_start(rpt_start), .rpt_count(rpt_count),
    .rpt_mode(rpt_mode), .instr_valid(instr_valid), .instr(instr),
    .idx_val(idx_val), .exec_done(exec_done), .jump_taken(jump_taken),
    .disconnect(disconnect), .issue(issue), .issue_instr(issue_instr),
    .reg7(reg7), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] b_step(input logic [14:0] f, input logic [2:0] m);
    case (m)
      3'd1, 3'd3: return f + 15'd1;
      3'd5, 3'd7: return f - 15'd1;
      default:    return f;
    endcase
  endfunction

  function automatic logic [14:0] b_first(input logic [23:0] w, input logic [14:0] ix);
    if (w[17:15] == 3'd0) return w[14:0];
    return w[14:0] + ix;
  endfunction

  task automatic run_trial(input logic [11:0] c, input logic [2:0] m,
                           input logic [23:0] w, input logic [14:0] ix,
                           input int jump_at, input int disc_at);
    logic [14:0] ef;
    int rem, it;
    bit fin, once, stp, jmp, dsc;
    rem  = c;
    it   = 0;
    fin  = 0;
    once = (w[23:18] >= 6'd1) && (w[23:18] <= 6'd7);
    ef   = b_first(w, ix);
    @(negedge clk);
    rpt_start = 1'b1; rpt_count = c; rpt_mode = m;
    @(negedge clk);
    rpt_start = 1'b0;
    chk(reg7 == {m, c}, "R2 load", 32'(reg7), 32'({m, c}));
    instr_valid = 1'b1; instr = w; idx_val = ix;
    @(negedge clk);
    instr_valid = 1'b0;
    if (c == 12'd0) begin
      chk(done && !issue, "R10 zero skip", {30'd0, done, issue}, 32'h2);
      chk(reg7 == 15'd0, "R10 reg7 after skip", 32'(reg7), 32'd0);
      fin = 1;
    end
    while (!fin) begin
      for (int k = 0; k < 20 && !issue && !done; k++) @(negedge clk);
      if (!issue) begin
        chk(1'b0, "R6 missing issue", 32'(done), 32'd0);
        fin = 1;
      end else begin
        it++;
        if (it == 1)
          chk(issue_instr == {w[23:15], ef}, "R3 first word", issue_instr, {w[23:15], ef});
        else
          chk(issue_instr == {w[23:15], ef}, "R4 stepped word", issue_instr, {w[23:15], ef});
        @(negedge clk);
        chk(!issue, "R5 pulse width", 32'(issue), 32'd0);
        @(negedge clk);
        chk(!issue, "R5 wait handshake", 32'(issue), 32'd0);
        dsc = (disc_at == it);
        jmp = (jump_at == it);
        if (dsc) begin
          disconnect = 1'b1;
          @(negedge clk);
          disconnect = 1'b0;
        end
        exec_done = 1'b1; jump_taken = jmp;
        @(negedge clk);
        exec_done = 1'b0; jump_taken = 1'b0;
        rem--;
        stp = (rem == 0) || jmp || dsc || once;
        if (stp) begin
          if (jmp)       chk(done && !issue, "R7 jump stop", {30'd0, done, issue}, 32'h2);
          else if (dsc)  chk(done && !issue, "R8 disconnect stop", {30'd0, done, issue}, 32'h2);
          else if (once) chk(done && !issue, "R9 once-only stop", {30'd0, done, issue}, 32'h2);
          else           chk(done && !issue, "R6 count end", {30'd0, done, issue}, 32'h2);
          chk(reg7 == {3'd0, 12'(rem)}, "R11 reg7 at end", 32'(reg7), 32'(rem));
          fin = 1;
        end else begin
          chk(reg7[11:0] == 12'(rem), "R6 count down", 32'(reg7[11:0]), 32'(rem));
          ef = b_step(ef, m);
        end
      end
    end
    if (c != 12'd0) chk(it == ((once || jump_at > 0 || disc_at > 0) ? it : int'(c)),
                        "R6 issue total", 32'(it), 32'(c));
    @(negedge clk);
    chk(!done && !issue, "R1 quiet after end", {30'd0, done, issue}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1957));
    repeat (3) @(negedge clk);
    chk(!issue && !done && reg7 == 15'd0, "R1 reset", {done, issue, reg7}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!issue && !done && reg7 == 15'd0, "R1 idle", {done, issue, reg7}, 32'd0);
    // directed corners
    run_trial(12'd3, 3'd1, 24'h30_0010, 15'd0, 0, 0);
    run_trial(12'd3, 3'd5, 24'h30_0000, 15'd0, 0, 0);
    run_trial(12'd4, 3'd2, 24'h30_1234, 15'd0, 0, 0);
    run_trial(12'd2, 3'd3, 24'h31_7FFF, 15'h7FFF, 0, 0);
    run_trial(12'd0, 3'd1, 24'h30_0005, 15'd0, 0, 0);
    run_trial(12'd5, 3'd1, 24'h0C_0020, 15'd0, 0, 0);
    run_trial(12'd6, 3'd7, 24'h40_0100, 15'd0, 2, 0);
    run_trial(12'd6, 3'd3, 24'h48_0100, 15'd3, 0, 3);
    run_trial(12'd1, 3'd0, 24'h50_0001, 15'd0, 0, 0);
    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [23:0] w;
      int c, ja, da;
      w = 24'($urandom);
      if (($urandom % 4) == 0) w[23:18] = 6'($urandom % 8);
      else w[23:18] = 6'(8 + ($urandom % 56));
      c  = $urandom % 9;
      ja = (($urandom % 3) == 0) ? 1 + ($urandom % 6) : 0;
      da = (($urandom % 4) == 0) ? 1 + ($urandom % 6) : 0;
      run_trial(12'(c), 3'($urandom), w, 15'($urandom), ja, da);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule